// File: doc/BRIEF.md
# Pixel Discard and Blend Control

This block sits near the end of a single-pass rendering pipeline and makes the final keep-or-drop decision for each pixel. It takes the depth-test and alpha-compare outcomes, a 3-bit coverage count with an overflow flag, an edge flag and the pixel's colors and alpha. From these it decides three things: whether the pixel is written, whether the downstream blender mixes it with memory, and which color is handed on. It also supplies the memory-side coverage and color when reading back the frame is switched off. Finally it trims the blender alpha to its five most significant bits.

Pixels enter on a valid/ready interface and leave, one cycle later, from a single output register. A pixel is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or its contents are being taken in the same cycle (`out_valid` and `out_ready`). While `out_valid` is high and `out_ready` is low, every output holds its value and no new pixel is taken. A discarded pixel still occupies an output slot, but with `out_wr` low, so pixel order and count are preserved. The mode bits are plain levels and are sampled together with the pixel they apply to.

Top module: `frag_gate`

## Requirements
- R1: A pixel accepted in cycle n appears on the outputs in cycle n+1 with `out_valid` high. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs stay unchanged.
- R2: When `mode_z_cmp_en` is 1 and `in_z_pass` is 0, the pixel is discarded (`out_wr` = 0).
- R3: When `mode_a_cmp_en` is 1 and `in_a_pass` is 0, the pixel is discarded.
- R4: With `mode_aa_en` = 1, a pixel whose coverage is zero (`in_cvg` = 0 and `in_cvg_ovf` = 0) is discarded.
- R5: With `mode_aa_en` = 0, a pixel whose `in_cvg` bit 0 is 0 is discarded. A pixel that meets none of the R2–R5 conditions has `out_wr` = 1.
- R6: `out_blend_en` is 1 when `mode_force_bl` is 1, or when `mode_aa_en` and `in_edge` are both 1. The only exception is R7.
- R7: When `mode_clr_cvg` and `in_cvg_ovf` are both 1, `out_blend_en` is 0 and `out_color` is the memory color (see R11).
- R8: Outside the R7 case, `out_color` equals `in_comb_color` unchanged, whether blending or not.
- R9: `out_no_div` is 1 exactly when `out_blend_en` is 1 and `mode_force_bl` is 1.
- R10: `out_blend_alpha` is bits [7:3] of `in_blend_alpha`.
- R11: With `mode_img_rd_en` = 0, `out_mem_cvg` is 7 and the memory color is 0. With it set to 1, `out_mem_cvg` equals `in_mem_cvg` and the memory color equals `in_mem_color`.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_z_pass | input | 1 | Depth test passed |
| in_a_pass | input | 1 | Alpha compare passed |
| in_cvg | input | 3 | Coverage count |
| in_cvg_ovf | input | 1 | Coverage overflow flag |
| in_edge | input | 1 | Pixel lies on a primitive edge |
| in_comb_color | input | CW | First blender input (combiner color) |
| in_mem_color | input | CW | Color read from the frame |
| in_mem_cvg | input | 3 | Coverage read from the frame |
| in_blend_alpha | input | 8 | Alpha for the blender |
| mode_aa_en | input | 1 | Anti-aliasing enable |
| mode_force_bl | input | 1 | Force blending |
| mode_clr_cvg | input | 1 | Take memory color on coverage overflow |
| mode_z_cmp_en | input | 1 | Depth test enable |
| mode_a_cmp_en | input | 1 | Alpha compare enable |
| mode_img_rd_en | input | 1 | Frame read-back enable |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_wr | output | 1 | Write strobe, low for discarded pixels |
| out_blend_en | output | 1 | Blender should mix |
| out_no_div | output | 1 | Blender skips its normalizing divide |
| out_color | output | CW | Color passed on |
| out_mem_cvg | output | 3 | Memory coverage for the blender |
| out_blend_alpha | output | 5 | Reduced blender alpha |

## Verification
Two functions can land on the same pixel: the coverage-overflow override of R7 and the blend enable of R6. A third overlap is a discard rule together with either of them. The stimulus biases the mode bits and the overflow flag so that force-blend, overflow and depth or alpha failures often coincide, and directed pixels hit each pairing outright. The expected result has the override winning over blending and the discard only lowering `out_wr`, and every output is judged against that on every cycle.

// File: rtl/fgate_pkg.sv
package fgate_pkg;
  localparam int CVG_W = 3;
  localparam logic [CVG_W-1:0] CVG_FULL = '1;

  typedef struct packed {
    logic aa_en;
    logic force_bl;
    logic clr_cvg;
    logic z_cmp_en;
    logic a_cmp_en;
    logic img_rd_en;
  } fg_mode_t;
endpackage

// File: rtl/fgate_reject.sv
module fgate_reject
  import fgate_pkg::*;
(
  input  fg_mode_t         mode,
  input  logic             z_pass,
  input  logic             a_pass,
  input  logic [CVG_W-1:0] cvg,
  input  logic             cvg_ovf,
  output logic             keep
);
  logic z_fail, a_fail, cov_empty, cov_fail;

  always_comb begin
    z_fail    = mode.z_cmp_en && !z_pass;
    a_fail    = mode.a_cmp_en && !a_pass;
    cov_empty = (cvg == '0) && !cvg_ovf;
    if (mode.aa_en) cov_fail = cov_empty;
    else            cov_fail = !cvg[0];
    keep = !(z_fail || a_fail || cov_fail);
  end
endmodule

// File: rtl/fgate_blend.sv
module fgate_blend
  import fgate_pkg::*;
#(
  parameter int CW    = 32,
  parameter int AIN_W = 8,
  parameter int AOUT_W = 5
) (
  input  fg_mode_t          mode,
  input  logic              edge_px,
  input  logic              cvg_ovf,
  input  logic [CW-1:0]     comb_color,
  input  logic [CW-1:0]     mem_color,
  input  logic [CVG_W-1:0]  mem_cvg,
  input  logic [AIN_W-1:0]  alpha_in,
  output logic              blend_en,
  output logic              no_div,
  output logic [CW-1:0]     color,
  output logic [CVG_W-1:0]  mem_cvg_o,
  output logic [AOUT_W-1:0] alpha_o
);
  logic          take_mem;
  logic [CW-1:0] mem_src;

  always_comb begin
    mem_src   = mode.img_rd_en ? mem_color : '0;
    mem_cvg_o = mode.img_rd_en ? mem_cvg : CVG_FULL;
    take_mem  = mode.clr_cvg && cvg_ovf;
    blend_en  = !take_mem && (mode.force_bl || (mode.aa_en && edge_px));
    no_div    = blend_en && mode.force_bl;
    color     = take_mem ? mem_src : comb_color;
  end

  generate
    if (AOUT_W >= AIN_W) begin : g_alpha_pad
      assign alpha_o = {alpha_in, {(AOUT_W - AIN_W){1'b0}}};
    end else begin : g_alpha_trunc
      assign alpha_o = alpha_in[AIN_W-1 -: AOUT_W];
    end
  endgenerate
endmodule

// File: rtl/fgate_stage.sv
module fgate_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign s_ready = !vld_q || m_ready;
  assign m_valid = vld_q;
  assign m_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (s_ready) begin
      vld_q <= s_valid;
      if (s_valid) dat_q <= s_data;
    end
  end
endmodule

// File: rtl/frag_gate.sv
module frag_gate
  import fgate_pkg::*;
#(
  parameter int CW     = 32,
  parameter int AIN_W  = 8,
  parameter int AOUT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_z_pass,
  input  logic              in_a_pass,
  input  logic [2:0]        in_cvg,
  input  logic              in_cvg_ovf,
  input  logic              in_edge,
  input  logic [CW-1:0]     in_comb_color,
  input  logic [CW-1:0]     in_mem_color,
  input  logic [2:0]        in_mem_cvg,
  input  logic [AIN_W-1:0]  in_blend_alpha,
  input  logic              mode_aa_en,
  input  logic              mode_force_bl,
  input  logic              mode_clr_cvg,
  input  logic              mode_z_cmp_en,
  input  logic              mode_a_cmp_en,
  input  logic              mode_img_rd_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_wr,
  output logic              out_blend_en,
  output logic              out_no_div,
  output logic [CW-1:0]     out_color,
  output logic [2:0]        out_mem_cvg,
  output logic [AOUT_W-1:0] out_blend_alpha
);
  localparam int PW = 3 + CW + CVG_W + AOUT_W;

  fg_mode_t          mode;
  logic              keep, blend_en, no_div;
  logic [CW-1:0]     color;
  logic [CVG_W-1:0]  mem_cvg;
  logic [AOUT_W-1:0] alpha;
  logic [PW-1:0]     pay_in, pay_out;
  logic              wr_q;

  assign mode = '{aa_en: mode_aa_en, force_bl: mode_force_bl, clr_cvg: mode_clr_cvg,
                  z_cmp_en: mode_z_cmp_en, a_cmp_en: mode_a_cmp_en,
                  img_rd_en: mode_img_rd_en};

  fgate_reject u_reject (
    .mode    (mode),
    .z_pass  (in_z_pass),
    .a_pass  (in_a_pass),
    .cvg     (in_cvg),
    .cvg_ovf (in_cvg_ovf),
    .keep    (keep)
  );

  fgate_blend #(.CW(CW), .AIN_W(AIN_W), .AOUT_W(AOUT_W)) u_blend (
    .mode       (mode),
    .edge_px    (in_edge),
    .cvg_ovf    (in_cvg_ovf),
    .comb_color (in_comb_color),
    .mem_color  (in_mem_color),
    .mem_cvg    (in_mem_cvg),
    .alpha_in   (in_blend_alpha),
    .blend_en   (blend_en),
    .no_div     (no_div),
    .color      (color),
    .mem_cvg_o  (mem_cvg),
    .alpha_o    (alpha)
  );

  assign pay_in = {keep, blend_en, no_div, color, mem_cvg, alpha};

  fgate_stage #(.W(PW)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (pay_in),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (pay_out)
  );

  assign {wr_q, out_blend_en, out_no_div, out_color, out_mem_cvg, out_blend_alpha} = pay_out;
  assign out_wr = wr_q && out_valid;
endmodule

// File: rtl/frag_gate_chk.sv
module frag_gate_chk #(
  parameter int CW     = 32,
  parameter int AIN_W  = 8,
  parameter int AOUT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_z_pass,
  input logic              in_a_pass,
  input logic [2:0]        in_cvg,
  input logic              in_cvg_ovf,
  input logic [CW-1:0]     in_mem_color,
  input logic [AIN_W-1:0]  in_blend_alpha,
  input logic              mode_aa_en,
  input logic              mode_force_bl,
  input logic              mode_clr_cvg,
  input logic              mode_z_cmp_en,
  input logic              mode_a_cmp_en,
  input logic              mode_img_rd_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_wr,
  input logic              out_blend_en,
  input logic              out_no_div,
  input logic [CW-1:0]     out_color,
  input logic [2:0]        out_mem_cvg,
  input logic [AOUT_W-1:0] out_blend_alpha
);
  logic fire;
  assign fire = in_valid && in_ready;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_color) && $stable(out_wr)
      && $stable(out_blend_en) && $stable(out_blend_alpha));
  assert_empty_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  assert_fire_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);
  assert_zfail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mode_z_cmp_en && !in_z_pass |=> !out_wr);
  assert_afail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mode_a_cmp_en && !in_a_pass |=> !out_wr);
  assert_cov_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mode_aa_en && in_cvg == 3'd0 && !in_cvg_ovf |=> !out_wr);
  assert_cov_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !mode_aa_en && !in_cvg[0] |=> !out_wr);
  assert_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mode_force_bl && !(mode_clr_cvg && in_cvg_ovf) |=> out_blend_en);
  assert_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mode_clr_cvg && in_cvg_ovf && mode_img_rd_en
      |=> !out_blend_en && out_color == $past(in_mem_color));
  assert_nodiv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_no_div |-> out_blend_en);
  assert_alpha_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_blend_alpha == AOUT_W'($past(in_blend_alpha) >> (AIN_W - AOUT_W)));
  assert_memcvg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !mode_img_rd_en |=> out_mem_cvg == 3'd7);
endmodule

bind frag_gate frag_gate_chk #(.CW(CW), .AIN_W(AIN_W), .AOUT_W(AOUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_z_pass(in_z_pass), .in_a_pass(in_a_pass), .in_cvg(in_cvg),
  .in_cvg_ovf(in_cvg_ovf), .in_mem_color(in_mem_color),
  .in_blend_alpha(in_blend_alpha), .mode_aa_en(mode_aa_en),
  .mode_force_bl(mode_force_bl), .mode_clr_cvg(mode_clr_cvg),
  .mode_z_cmp_en(mode_z_cmp_en), .mode_a_cmp_en(mode_a_cmp_en),
  .mode_img_rd_en(mode_img_rd_en), .out_valid(out_valid), .out_ready(out_ready),
  .out_wr(out_wr), .out_blend_en(out_blend_en), .out_no_div(out_no_div),
  .out_color(out_color), .out_mem_cvg(out_mem_cvg), .out_blend_alpha(out_blend_alpha)
);

// File: tb/frag_gate_test.sv
`timescale 1ns/1ps
module frag_gate_test;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_z_pass = 0, in_a_pass = 0, in_cvg_ovf = 0, in_edge = 0;
  logic [2:0] in_cvg = 0, in_mem_cvg = 0;
  logic [CW-1:0] in_comb_color = 0, in_mem_color = 0;
  logic [7:0] in_blend_alpha = 0;
  logic m_aa = 0, m_fb = 0, m_clr = 0, m_z = 0, m_a = 0, m_rd = 0;
  logic out_ready = 0;
  logic in_ready, out_valid, out_wr, out_blend_en, out_no_div;
  logic [CW-1:0] out_color;
  logic [2:0] out_mem_cvg;
  logic [4:0] out_blend_alpha;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  frag_gate #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_z_pass(in_z_pass), .in_a_pass(in_a_pass), .in_cvg(in_cvg),
    .in_cvg_ovf(in_cvg_ovf), .in_edge(in_edge), .in_comb_color(in_comb_color),
    .in_mem_color(in_mem_color), .in_mem_cvg(in_mem_cvg),
    .in_blend_alpha(in_blend_alpha), .mode_aa_en(m_aa), .mode_force_bl(m_fb),
    .mode_clr_cvg(m_clr), .mode_z_cmp_en(m_z), .mode_a_cmp_en(m_a),
    .mode_img_rd_en(m_rd), .out_valid(out_valid), .out_ready(out_ready),
    .out_wr(out_wr), .out_blend_en(out_blend_en), .out_no_div(out_no_div),
    .out_color(out_color), .out_mem_cvg(out_mem_cvg), .out_blend_alpha(out_blend_alpha)
  );

  typedef struct {
    bit wr; bit ben; bit nd; logic [CW-1:0] col; logic [2:0] mc; logic [4:0] al;
    bit from_mem;
  } exp_t;

  exp_t q[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic exp_t predict();
    exp_t e;
    bit drop = 0;
    logic [CW-1:0] mcol;
    if (m_z && !in_z_pass) drop = 1;
    if (m_a && !in_a_pass) drop = 1;
    if (m_aa) begin
      if (in_cvg == 0 && !in_cvg_ovf) drop = 1;
    end else if (in_cvg[0] == 0) drop = 1;
    e.wr = !drop;
    mcol = m_rd ? in_mem_color : '0;
    e.mc = m_rd ? in_mem_cvg : 3'd7;
    e.from_mem = m_clr && in_cvg_ovf;
    if (e.from_mem) begin
      e.ben = 0; e.col = mcol;
    end else begin
      e.ben = m_fb || (m_aa && in_edge); e.col = in_comb_color;
    end
    e.nd = e.ben && m_fb;
    e.al = in_blend_alpha / 8;
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) q.delete();
    else begin
      if (out_valid && out_ready && q.size() > 0) void'(q.pop_front());
      if (in_valid && in_ready) q.push_back(predict());
    end
  end

  task automatic compare();
    exp_t e;
    check(out_valid == (q.size() != 0), "R1 out_valid", out_valid, q.size() != 0);
    check(in_ready == (!out_valid || out_ready), "R1 in_ready", in_ready, !out_valid || out_ready);
    if (out_valid && q.size() != 0) begin
      e = q[0];
      check(out_wr == e.wr, "R2 R3 R4 R5 write strobe", out_wr, e.wr);
      check(out_blend_en == e.ben, e.from_mem ? "R7 blend off" : "R6 blend enable", out_blend_en, e.ben);
      check(out_no_div == e.nd, "R9 no divide", out_no_div, e.nd);
      check(out_color == e.col, e.from_mem ? "R7 memory color" : "R8 pass color", out_color, e.col);
      check(out_mem_cvg == e.mc, "R11 memory coverage", out_mem_cvg, e.mc);
      check(out_blend_alpha == e.al, "R10 alpha", out_blend_alpha, e.al);
    end
  endtask

  task automatic drive(input bit v, input bit zp, input bit ap, input logic [2:0] cv,
                       input bit ov, input bit ed, input bit aa, input bit fb, input bit clr,
                       input bit z, input bit a, input bit rd, input bit rdy);
    in_valid = v; in_z_pass = zp; in_a_pass = ap; in_cvg = cv; in_cvg_ovf = ov;
    in_edge = ed; m_aa = aa; m_fb = fb; m_clr = clr; m_z = z; m_a = a; m_rd = rd;
    out_ready = rdy;
    in_comb_color = $urandom; in_mem_color = $urandom;
    in_mem_cvg = 3'($urandom); in_blend_alpha = 8'($urandom);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 0, "R12 reset out_valid", out_valid, 0);
    check(in_ready == 1, "R12 reset in_ready", in_ready, 1);
    rst_n = 1'b1;
    // directed: each discard rule, overlaps of override/blend/discard
    @(negedge clk); compare(); drive(1,0,1,3'd7,0,0,0,0,0,1,0,1,1); // R2 depth fail
    @(negedge clk); compare(); drive(1,1,0,3'd7,0,0,0,0,0,0,1,1,1); // R3 alpha fail
    @(negedge clk); compare(); drive(1,1,1,3'd0,0,1,1,0,0,0,0,1,1); // R4 zero coverage
    @(negedge clk); compare(); drive(1,1,1,3'd0,1,1,1,0,0,0,0,1,1); // R4 overflow only: kept
    @(negedge clk); compare(); drive(1,1,1,3'd6,0,0,0,0,0,0,0,1,1); // R5 even coverage
    @(negedge clk); compare(); drive(1,1,1,3'd5,0,1,1,0,0,0,0,1,1); // R6 edge blend
    @(negedge clk); compare(); drive(1,1,1,3'd1,1,1,1,1,1,0,0,1,1); // R7 over R6 force
    @(negedge clk); compare(); drive(1,0,1,3'd1,1,0,0,1,1,1,0,0,1); // R7 with R2, R11 read off
    @(negedge clk); compare(); drive(1,1,1,3'd3,0,0,0,1,0,0,0,0,1); // R9 force no divide
    @(negedge clk); compare(); drive(1,1,1,3'd3,0,0,0,0,0,0,0,1,0); // R1 stall start
    @(negedge clk); compare(); drive(1,1,1,3'd3,0,1,1,1,0,0,0,1,0); // R1 held
    @(negedge clk); compare(); drive(0,1,1,3'd3,0,0,0,0,0,0,0,1,1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); compare();
      drive(($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 3) != 0,
            3'($urandom), ($urandom % 3) == 0, $urandom % 2,
            $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
            $urandom % 2, ($urandom % 4) != 0);
    end
    @(negedge clk); compare(); drive(0,1,1,3'd1,0,0,0,0,0,0,0,1,1);
    repeat (3) begin @(negedge clk); compare(); end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule